// File: doc/BRIEF.md
# Non-Preemptive Memory Bus Slot Arbiter

This block shares one pipelined memory bus between two requesters: demand misses coming out of the secondary cache, and prefetches waiting in the prefetch buffer. Each granted access holds the bus issue slot for a fixed number of cycles, `SLOT_CYCLES`. A new access can start only when the slot is free.

A demand miss wins any free slot over a prefetch. A prefetch that has already been granted keeps the slot until its occupancy ends, and a later demand miss cannot interrupt it. A demand miss can therefore wait almost a full slot.

A prefetch that hit in the secondary cache is flagged by its requester. Such a request is never granted and never consumes bus time. Each grant is a combinational one-cycle pulse. It carries a source tag so that the return path can be routed.

Top module: `membus_arb`

## Requirements
- R1: After reset `busy` is 0 and no grant is asserted while no request is present. A request presented in the first cycle after reset is granted in that same cycle.
- R2: When the slot is free, a valid request is granted combinationally in the cycle it is presented.
- R3: Each cycle asserts at most one of `dmd_gnt` and `pf_gnt`. A request held high after its grant receives no further grant until the slot frees again.
- R4: Two grants are always at least `SLOT_CYCLES` cycles apart. With a request held continuously, grants come exactly every `SLOT_CYCLES` cycles.
- R5: If both a demand request and a valid prefetch request are present while the slot is free, `dmd_gnt` is asserted and `pf_gnt` is not.
- R6: A granted prefetch keeps the slot for its full occupancy. A demand request that arrives in the cycle after the prefetch grant is granted exactly `SLOT_CYCLES-1` cycles later, and not earlier.
- R7: While `pf_l2_hit` is 1, a prefetch request is ignored. It produces no grant and leaves `busy` at 0.
- R8: `gnt_src` is 2'b01 for a demand grant, 2'b10 for a prefetch grant and 2'b00 when no grant is asserted.
- R9: `busy` is 1 in each of the `SLOT_CYCLES-1` cycles that follow a grant cycle and 0 otherwise. A grant is only possible while `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dmd_req | input | 1 | Demand miss request, held until granted |
| pf_req | input | 1 | Prefetch request, held until granted |
| pf_l2_hit | input | 1 | Prefetch hit in secondary cache; masks `pf_req` |
| dmd_gnt | output | 1 | One-cycle demand grant |
| pf_gnt | output | 1 | One-cycle prefetch grant |
| gnt_src | output | 2 | Source tag of the current grant |
| busy | output | 1 | Slot occupied, no grant possible this cycle |

## Verification
The bench builds the arbiter with `SLOT_CYCLES` set to 5 rather than 20. This keeps each slot short enough that continuous back-to-back grants, the full wait of a demand behind a prefetch and several idle recoveries all fit in a brief run. Every expected cycle count is derived from that parameter. The same checks therefore cover the edge where the down-counter reaches zero and the next grant is taken in that same cycle.

// File: rtl/membus_arb_pkg.sv
package membus_arb_pkg;

    typedef enum logic [1:0] {
        SRC_NONE     = 2'b00,
        SRC_DEMAND   = 2'b01,
        SRC_PREFETCH = 2'b10
    } src_e;

    typedef struct packed {
        logic dmd;
        logic pf;
        src_e src;
    } grant_t;

    // Fixed-priority selection for one free slot
    function automatic grant_t pick_grant(input logic dmd_req,
                                          input logic pf_valid,
                                          input logic free);
        grant_t g;
        g = '{dmd: 1'b0, pf: 1'b0, src: SRC_NONE};
        if (free) begin
            if (dmd_req) begin
                g.dmd = 1'b1;
                g.src = SRC_DEMAND;
            end else if (pf_valid) begin
                g.pf  = 1'b1;
                g.src = SRC_PREFETCH;
            end
        end
        return g;
    endfunction

endpackage

// File: rtl/arb_slot_timer.sv
module arb_slot_timer #(
    parameter int SLOT_CYCLES = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic take,
    output logic busy
);
    localparam int CNT_W = (SLOT_CYCLES > 2) ? $clog2(SLOT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(SLOT_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (take)
            cnt <= LOAD;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    // R9: a slot can only be taken while it is free
    a_r9_take_when_free: assert property (@(posedge clk) disable iff (rst)
        take |-> !busy);

    // R6: an occupied slot only counts down, it is never reloaded
    a_r6_no_preempt: assert property (@(posedge clk) disable iff (rst)
        busy |=> (CNT_W'(cnt + 1'b1) == $past(cnt)));

endmodule

// File: rtl/arb_pick.sv
module arb_pick
    import membus_arb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   dmd_req,
    input  logic   pf_req,
    input  logic   pf_l2_hit,
    input  logic   free,
    output grant_t gnt
);
    logic pf_valid;

    assign pf_valid = pf_req && !pf_l2_hit;
    assign gnt      = pick_grant(dmd_req, pf_valid, free);

    // R3: never two grants at once
    a_r3_one_grant: assert property (@(posedge clk) disable iff (rst)
        !(gnt.dmd && gnt.pf));

    // R7: a prefetch that hit in the secondary cache never reaches the bus
    a_r7_hit_masked: assert property (@(posedge clk) disable iff (rst)
        pf_l2_hit |-> !gnt.pf);

endmodule

// File: rtl/membus_arb.sv
module membus_arb
    import membus_arb_pkg::*;
#(
    parameter int SLOT_CYCLES = 20
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       dmd_req,
    input  logic       pf_req,
    input  logic       pf_l2_hit,
    output logic       dmd_gnt,
    output logic       pf_gnt,
    output logic [1:0] gnt_src,
    output logic       busy
);
    grant_t gnt;
    logic   take;

    arb_pick u_pick (
        .clk       (clk),
        .rst       (rst),
        .dmd_req   (dmd_req),
        .pf_req    (pf_req),
        .pf_l2_hit (pf_l2_hit),
        .free      (!busy),
        .gnt       (gnt)
    );

    assign take = gnt.dmd || gnt.pf;

    arb_slot_timer #(.SLOT_CYCLES(SLOT_CYCLES)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .take (take),
        .busy (busy)
    );

    assign dmd_gnt = gnt.dmd;
    assign pf_gnt  = gnt.pf;
    assign gnt_src = gnt.src;

    // R5: demand wins a free slot
    a_r5_demand_first: assert property (@(posedge clk) disable iff (rst)
        (dmd_req && !busy) |-> (dmd_gnt && !pf_gnt));

    // R9: a grant occupies the slot on the next cycle
    a_r9_busy_after_grant: assert property (@(posedge clk) disable iff (rst)
        (dmd_gnt || pf_gnt) |=> busy);

    // R8: tag follows the granted source
    a_r8_tag: assert property (@(posedge clk) disable iff (rst)
        (dmd_gnt |-> gnt_src == 2'b01) and (pf_gnt |-> gnt_src == 2'b10));

endmodule

// File: tb/sim_membus_arb.sv
module sim_membus_arb;
    localparam int SLOT = 5;

    logic       clk = 1'b0;
    logic       rst;
    logic       dmd_req, pf_req, pf_l2_hit;
    logic       dmd_gnt, pf_gnt, busy;
    logic [1:0] gnt_src;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    membus_arb #(.SLOT_CYCLES(SLOT)) u0 (
        .clk(clk), .rst(rst), .dmd_req(dmd_req), .pf_req(pf_req),
        .pf_l2_hit(pf_l2_hit), .dmd_gnt(dmd_gnt), .pf_gnt(pf_gnt),
        .gnt_src(gnt_src), .busy(busy)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive inputs just after a falling edge, then settle before sampling
    task automatic cyc(logic d, logic p, logic h);
        @(negedge clk);
        dmd_req = d; pf_req = p; pf_l2_hit = h;
        #2;
    endtask

    task automatic idle_out();
        for (int i = 0; i < SLOT; i++) cyc(0, 0, 0);
    endtask

    task automatic t_reset();
        rst = 1'b1; dmd_req = 0; pf_req = 0; pf_l2_hit = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #2;
        check("R1 busy", busy, 0);
        check("R1 no grant", dmd_gnt | pf_gnt, 0);
        check("R8 idle tag", gnt_src, 0);
        cyc(1, 0, 0);
        check("R1 first grant", dmd_gnt, 1);
        idle_out();
    endtask

    task automatic t_single_prefetch();
        cyc(0, 1, 0);
        check("R2 pf grant", pf_gnt, 1);
        check("R8 pf tag", gnt_src, 2);
        cyc(0, 1, 0);
        check("R3 single pulse", pf_gnt, 0);
        check("R9 busy after", busy, 1);
        for (int i = 2; i < SLOT; i++) begin
            cyc(0, 0, 0);
            check("R9 busy hold", busy, 1);
        end
        cyc(0, 0, 0);
        check("R9 busy clear", busy, 0);
    endtask

    task automatic t_priority();
        cyc(1, 1, 0);
        check("R5 demand wins", dmd_gnt, 1);
        check("R5 pf held", pf_gnt, 0);
        check("R8 dmd tag", gnt_src, 1);
        for (int i = 1; i < SLOT; i++) cyc(0, 1, 0);
        cyc(0, 1, 0);
        check("R2 pf after slot", pf_gnt, 1);
        idle_out();
    endtask

    task automatic t_no_preempt();
        int wait_n = 0;
        cyc(0, 1, 0);
        check("R6 pf granted", pf_gnt, 1);
        for (int i = 0; i < 4 * SLOT; i++) begin
            cyc(1, 0, 0);
            if (dmd_gnt) break;
            if (pf_gnt) check("R3 stray pf", 1, 0);
            wait_n++;
        end
        check("R6 demand wait", wait_n, SLOT - 1);
        idle_out();
    endtask

    task automatic t_l2_hit();
        for (int i = 0; i < SLOT + 2; i++) begin
            cyc(0, 1, 1);
            check("R7 hit no grant", pf_gnt, 0);
            check("R7 hit not busy", busy, 0);
        end
        cyc(0, 1, 0);
        check("R7 miss granted", pf_gnt, 1);
        idle_out();
    endtask

    task automatic t_back_to_back();
        int last = -1;
        int n = 0;
        for (int i = 0; i < 3 * SLOT + 1; i++) begin
            cyc(1, 0, 0);
            if (dmd_gnt) begin
                if (last >= 0) check("R4 spacing", i - last, SLOT);
                last = i;
                n++;
            end
        end
        check("R4 grant count", n, 4);
        idle_out();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 20000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_single_prefetch();
        t_priority();
        t_no_preempt();
        t_l2_hit();
        t_back_to_back();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule